// File: doc/BRIEF.md
# Legacy Fast Kernel Entry Unit

This block computes the processor state for a fast jump into an operating system entry point in 32-bit legacy mode. Software first loads three 32-bit configuration registers through a write port. The registers hold a code selector, a kernel stack pointer and an entry offset. When `start_i` is pulsed, the block produces the new code and stack selectors, the flat segment bases, limits and attributes, the new stack and instruction pointers, and privilege level 0. The result arrives on the next cycle, together with `done_o`.

No descriptor table is read. The stack selector is always the code selector plus 8. No return address or caller stack pointer is kept. If the request arrives while the core is not in legacy mode, the block flags an undefined-opcode fault and leaves every state output unchanged. Committing the result, delivering the fault and the matching return path belong to other blocks.

Top module: `fast_entry_unit`

## Requirements
- R1: After reset, the three configuration registers and all state outputs are zero, except `cpl_o`, which is 3. `done_o` and `fault_ud_o` are 0.
- R2: A write with `wr_en_i` high stores `wr_data_i` at address 0 (code selector, only bits 15:0 kept), address 1 (stack pointer) or address 2 (entry offset). A write to address 3 changes nothing.
- R3: `done_o` is high in exactly the cycle after each cycle in which `start_i` is high, and low otherwise.
- R4: After a legacy entry, `cs_sel_o` equals bits 15:0 of the code selector register, and `ss_sel_o` equals that value plus 8, modulo 2^16.
- R5: After a legacy entry, `stack_ptr_o` equals the stack pointer register and `instr_ptr_o` equals the entry offset register.
- R6: After a legacy entry, both limits are 0xFFFF_FFFF, both bases are 0, `cpl_o` is 0, `cs_attr_o` is 0xCA and `ss_attr_o` is 0xC2. The attribute layout is: bit 7 present, bit 6 32-bit size, bits 5:4 privilege, bits 3:0 type. Type 1010 is execute/read code and type 0010 is read/write expand-up data.
- R7: A start with `legacy_i` low raises `fault_ud_o` together with `done_o` for one cycle, and leaves every state output at its previous value.
- R8: The state outputs change only in a cycle in which `done_o` is high without a fault. Configuration writes alone do not alter them.
- R9: A start in the same cycle as a configuration write uses the register value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Configuration write enable |
| wr_addr_i | input | 2 | Configuration register address |
| wr_data_i | input | 32 | Configuration write data |
| start_i | input | 1 | Request a kernel entry |
| legacy_i | input | 1 | Core is in 32-bit legacy mode |
| done_o | output | 1 | Result valid, one cycle after start |
| fault_ud_o | output | 1 | Undefined-opcode fault for this request |
| cs_sel_o | output | 16 | New code selector |
| ss_sel_o | output | 16 | New stack selector |
| cs_base_o | output | 32 | Code segment base |
| ss_base_o | output | 32 | Stack segment base |
| cs_limit_o | output | 32 | Code segment limit |
| ss_limit_o | output | 32 | Stack segment limit |
| cs_attr_o | output | 8 | Code segment attributes |
| ss_attr_o | output | 8 | Stack segment attributes |
| stack_ptr_o | output | 32 | New stack pointer |
| instr_ptr_o | output | 32 | New instruction pointer |
| cpl_o | output | 2 | Current privilege level |

## Verification
On every cycle, the assertions check that `done_o` follows `start_i` by one cycle and that a fault never appears without `done_o`. They also check that a fault or an idle cycle leaves the state outputs stable, and that a successful entry produces the selector offset of 8, privilege 0 and the fixed attributes. The following are shown only by the bench's scenarios against its reference model: the actual register contents reaching the outputs, the ignored write address, the discarded upper selector bits, the selector wrap at 0xFFFC, and the use of the old register value when a write and a start share a cycle.

// File: rtl/fast_entry_unit.sv
module fast_entry_unit #(
  parameter int XLEN  = 32,
  parameter int SEL_W = 16,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [XLEN-1:0]  wr_data_i,
  input  logic             start_i,
  input  logic             legacy_i,
  output logic             done_o,
  output logic             fault_ud_o,
  output logic [SEL_W-1:0] cs_sel_o,
  output logic [SEL_W-1:0] ss_sel_o,
  output logic [XLEN-1:0]  cs_base_o,
  output logic [XLEN-1:0]  ss_base_o,
  output logic [XLEN-1:0]  cs_limit_o,
  output logic [XLEN-1:0]  ss_limit_o,
  output logic [7:0]       cs_attr_o,
  output logic [7:0]       ss_attr_o,
  output logic [XLEN-1:0]  stack_ptr_o,
  output logic [XLEN-1:0]  instr_ptr_o,
  output logic [1:0]       cpl_o
);
  localparam logic [AW-1:0]    ADDR_SEL   = AW'(0);
  localparam logic [AW-1:0]    ADDR_SP    = AW'(1);
  localparam logic [AW-1:0]    ADDR_IP    = AW'(2);
  localparam logic [7:0]       CODE_ATTR  = 8'hCA;
  localparam logic [7:0]       STACK_ATTR = 8'hC2;
  localparam logic [XLEN-1:0]  FLAT_LIM   = '1;
  localparam logic [SEL_W-1:0] SS_STEP    = SEL_W'(8);

  logic [SEL_W-1:0] sel_q;
  logic [XLEN-1:0]  sp_q, ip_q;
  logic             enter;

  assign enter     = start_i & legacy_i;
  assign cs_base_o = '0;
  assign ss_base_o = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      sp_q  <= '0;
      ip_q  <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_SEL) sel_q <= wr_data_i[SEL_W-1:0];
      if (wr_addr_i == ADDR_SP)  sp_q  <= wr_data_i;
      if (wr_addr_i == ADDR_IP)  ip_q  <= wr_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o      <= 1'b0;
      fault_ud_o  <= 1'b0;
      cs_sel_o    <= '0;
      ss_sel_o    <= '0;
      cs_limit_o  <= '0;
      ss_limit_o  <= '0;
      cs_attr_o   <= '0;
      ss_attr_o   <= '0;
      stack_ptr_o <= '0;
      instr_ptr_o <= '0;
      cpl_o       <= 2'd3;
    end else begin
      done_o     <= start_i;
      fault_ud_o <= start_i & ~legacy_i;
      if (enter) begin
        cs_sel_o    <= sel_q;
        ss_sel_o    <= sel_q + SS_STEP;
        cs_limit_o  <= FLAT_LIM;
        ss_limit_o  <= FLAT_LIM;
        cs_attr_o   <= CODE_ATTR;
        ss_attr_o   <= STACK_ATTR;
        stack_ptr_o <= sp_q;
        instr_ptr_o <= ip_q;
        cpl_o       <= 2'd0;
      end
    end
  end

  // R3
  done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  // R3
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);
  // R7
  fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_ud_o |-> done_o);
  // R7
  fault_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !legacy_i) |=> ($stable(cs_sel_o) && $stable(ss_sel_o) &&
      $stable(stack_ptr_o) && $stable(instr_ptr_o) && $stable(cpl_o) && $stable(cs_attr_o)));
  // R8
  idle_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(cs_sel_o) && $stable(ss_sel_o) && $stable(stack_ptr_o) &&
      $stable(instr_ptr_o) && $stable(cpl_o) && $stable(cs_limit_o)));
  // R4
  ss_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !fault_ud_o) |-> (ss_sel_o == cs_sel_o + SS_STEP));
  // R6
  flat_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !fault_ud_o) |-> (cpl_o == 2'd0 && cs_attr_o == CODE_ATTR &&
      ss_attr_o == STACK_ATTR && cs_limit_o == FLAT_LIM && ss_limit_o == FLAT_LIM));
endmodule

// File: tb/fast_entry_unit_tb.sv
`timescale 1ns/1ps
module fast_entry_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, start = 1'b0, legacy = 1'b1;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic done, fault;
  logic [15:0] cs_sel, ss_sel;
  logic [31:0] cs_base, ss_base, cs_lim, ss_lim, sp, ip;
  logic [7:0] cs_attr, ss_attr;
  logic [1:0] cpl;
  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  fast_entry_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .start_i(start), .legacy_i(legacy), .done_o(done), .fault_ud_o(fault),
    .cs_sel_o(cs_sel), .ss_sel_o(ss_sel), .cs_base_o(cs_base), .ss_base_o(ss_base),
    .cs_limit_o(cs_lim), .ss_limit_o(ss_lim), .cs_attr_o(cs_attr), .ss_attr_o(ss_attr),
    .stack_ptr_o(sp), .instr_ptr_o(ip), .cpl_o(cpl));

  // behavioural reference
  logic [31:0] cfg [3];
  logic [31:0] e_cs, e_ss, e_lim, e_sp, e_ip, e_cattr, e_sattr, e_cpl;
  logic e_done, e_fault;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (cfg[k]) cfg[k] = 0;
      e_cs = 0; e_ss = 0; e_lim = 0; e_sp = 0; e_ip = 0;
      e_cattr = 0; e_sattr = 0; e_cpl = 3; e_done = 0; e_fault = 0;
    end else begin
      e_done = start;
      e_fault = start && !legacy;
      if (start && legacy) begin
        e_cs = cfg[0] % 65536;
        e_ss = (cfg[0] + 8) % 65536;
        e_sp = cfg[1];
        e_ip = cfg[2];
        e_lim = 32'hFFFF_FFFF;
        e_cattr = 32'hCA;
        e_sattr = 32'hC2;
        e_cpl = 0;
      end
      if (wr_en && wr_addr != 2'd3) cfg[wr_addr] = (wr_addr == 2'd0) ? (wr_data & 32'hFFFF) : wr_data;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R3", "done", 32'(done), 32'(e_done));
    chk("R7", "fault", 32'(fault), 32'(e_fault));
    chk("R4", "cs_sel", 32'(cs_sel), e_cs);
    chk("R4", "ss_sel", 32'(ss_sel), e_ss);
    chk("R5", "stack_ptr", sp, e_sp);
    chk("R5", "instr_ptr", ip, e_ip);
    chk("R6", "cs_limit", cs_lim, e_lim);
    chk("R6", "ss_limit", ss_lim, e_lim);
    chk("R6", "bases", cs_base | ss_base, 32'd0);
    chk("R6", "cs_attr", 32'(cs_attr), e_cattr);
    chk("R6", "ss_attr", 32'(ss_attr), e_sattr);
    chk("R6", "cpl", 32'(cpl), e_cpl);
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=5000", cycles);
      finish_run();
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic go(logic leg);
    @(negedge clk); start = 1; legacy = leg;
    @(negedge clk); start = 0; legacy = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset cpl", 32'(cpl), 32'd3);
    chk("R1", "reset done", 32'(done), 32'd0);
    chk("R1", "reset ip", ip, 32'd0);
    chk("R1", "reset cs_sel", 32'(cs_sel), 32'd0);
    go(1);
    chk("R1", "zero cfg ss_sel", 32'(ss_sel), 32'd8);
    // R2 writes, upper selector bits dropped
    wr(0, 32'hABCD_0023); wr(1, 32'h0008_F000); wr(2, 32'hC010_2000);
    go(1);
    chk("R2", "cs_sel", 32'(cs_sel), 32'h0023);
    chk("R4", "ss_sel", 32'(ss_sel), 32'h002B);
    chk("R5", "ip", ip, 32'hC010_2000);
    // R2 address 3 ignored
    wr(3, 32'h5555_5555);
    go(1);
    chk("R2", "addr3 ip", ip, 32'hC010_2000);
    chk("R2", "addr3 sp", sp, 32'h0008_F000);
    // R8 writes alone do not change outputs
    wr(1, 32'h1111_2222);
    repeat (2) @(negedge clk);
    chk("R8", "sp held", sp, 32'h0008_F000);
    // R7 non-legacy start faults and holds
    wr(2, 32'h7777_0000);
    @(negedge clk); start = 1; legacy = 0;
    @(negedge clk); start = 0; legacy = 1;
    chk("R7", "fault", 32'(fault), 32'd1);
    chk("R7", "ip held", ip, 32'hC010_2000);
    // R9 write and start in same cycle
    @(negedge clk); start = 1; wr_en = 1; wr_addr = 2; wr_data = 32'h9999_0000;
    @(negedge clk); start = 0; wr_en = 0;
    chk("R9", "old ip used", ip, 32'h7777_0000);
    go(1);
    chk("R9", "new ip later", ip, 32'h9999_0000);
    // R4 wrap
    wr(0, 32'h0000_FFFC);
    go(1);
    chk("R4", "ss wrap", 32'(ss_sel), 32'h0004);
    // R3 back-to-back starts
    @(negedge clk); start = 1;
    @(negedge clk); chk("R3", "b2b first", 32'(done), 32'd1);
    @(negedge clk); start = 0; chk("R3", "b2b second", 32'(done), 32'd1);
    @(negedge clk); chk("R3", "b2b end", 32'(done), 32'd0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule